// File: doc/BRIEF.md
# Saturating Cache Event Counter Unit

This block watches single-cycle event pulses raised by a cache controller and counts them in two equal 32-bit counters. Each counter is bound, by a 4-bit source code in its own configuration register, to one pulse line out of a coded menu. The menu holds base cache events and, when the `HAS_EXT` parameter is set, a group of prefetch and speculative-read events. A counter that reaches all-ones stays there rather than wrapping. Software can therefore always tell that the count ran out, and it is expected to poll and re-zero the counters before that happens.

Software reaches the unit over a plain register bus. A request is one cycle with `bus_valid` high. Writes take effect at that clock edge. Read data is registered and appears on `bus_rdata` one cycle after the request. The bus never stalls, so it has no ready or back-pressure signal.

The registers are:
- a control register holding the global enable;
- a status register of sticky saturation flags, cleared by writing 1;
- two configuration registers, one per counter;
- two value registers, one per counter.

The per-counter registers run in descending address order: counter 1 sits one word below counter 0. A flag can raise `irq_o` when a counter saturates.

Top module: `cache_evt_counters`

## Requirements
- R1: After reset:
  - both counters read 0;
  - the control, status and both configuration registers read 0;
  - `irq_o` is 0.
- R2: The control register at byte address 0x00 holds the global enable in bit 0, and its other bits read 0.
  - While bit 0 is 0, no counter advances.
  - Writing it back with other bits set stores only bit 0.
- R3: A counter at 0xFFFFFFFF keeps that value on further selected events. It never wraps to 0.
- R4: A configuration register holds the source code in bits [5:2] and the interrupt field in bits [1:0].
  - Source code 0 disables the counter: it ignores every pulse.
  - Codes 1 to 9 count `evt_i[code]`: 1 eviction, 2 data read hit, 3 data read request, 4 data write hit, 5 data write request, 6 write-through request, 7 instruction read hit, 8 instruction read request, 9 write allocate.
- R5: Codes 0xA to 0xF count `evt_i[code]`:
  - 0xA prefetch allocate;
  - 0xB external prefetch hit;
  - 0xC external prefetch allocate;
  - 0xD speculative read received;
  - 0xE speculative read confirmed;
  - 0xF external prefetch received.

  When `HAS_EXT` is 0, these codes never count.
- R6: Counter n has its configuration register at 0x0C - 4n and its value register at 0x14 - 4n. So counter 1 uses 0x08 and 0x10, and counter 0 uses 0x0C and 0x14. The two counters are independent.
- R7: A value register can be written and read back.
  - A write lands at the request edge.
  - An event pulse for that counter in the same cycle as the write is dropped.
- R8: When an event moves a counter from 0xFFFFFFFE to 0xFFFFFFFF and its interrupt field is nonzero, status bit n sets at byte address 0x04. It stays set until software writes 1 to that bit. An interrupt field of 0 leaves the flag clear.
- R9: `irq_o` is 1 exactly while some status flag is set for a counter whose interrupt field is nonzero.
- R10: Read data appears on `bus_rdata` in the cycle after the read request. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 15 | Event pulses, bit k is source code k (k = 1..15) |
| bus_valid | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| irq_o | output | 1 | Saturation interrupt |

## Verification
An event pulse held for one cycle moves the counter at the edge that samples it. A value write lands at its request edge. A status flag and `irq_o` change at the same edge as the count that reaches all-ones. Read data is due one edge after the request.

The bench drives every input on the falling edge and holds it for exactly one cycle. It samples `irq_o` and `bus_rdata` at the next falling edge, which is half a cycle after the edge that settles them. Every counter result is read back through the bus after the stimulus and before the next one, so each check looks at the first cycle in which the value is due.

// File: rtl/cec_pkg.sv
package cec_pkg;
  localparam int NUM_CNT  = 2;
  localparam int SRC_W    = 4;
  localparam int NUM_SRC  = 1 << SRC_W;
  localparam int BASE_LAST = 9;
  localparam int IRQ_W    = 2;
  localparam int CFG_W    = SRC_W + IRQ_W;
  localparam int ADDR_W   = 8;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h00;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h04;
  localparam logic [ADDR_W-1:0] CFG0_ADDR = 8'h0C;
  localparam logic [ADDR_W-1:0] VAL0_ADDR = 8'h14;

  function automatic logic [ADDR_W-1:0] cfg_addr(input int n);
    return CFG0_ADDR - ADDR_W'(4 * n);
  endfunction

  function automatic logic [ADDR_W-1:0] val_addr(input int n);
    return VAL0_ADDR - ADDR_W'(4 * n);
  endfunction
endpackage

// File: rtl/cec_evt_select.sv
module cec_evt_select
  import cec_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1
) (
  input  logic [NUM_SRC-1:1] evt_i,
  input  logic [SRC_W-1:0]   sel_i,
  output logic               hit_o
);
  logic [NUM_SRC-1:0] usable;

  assign usable[0] = 1'b0;  // code 0: counter disabled

  for (genvar k = 1; k < NUM_SRC; k++) begin : g_src
    if (k > BASE_LAST && !HAS_EXT) begin : g_off
      assign usable[k] = 1'b0;
    end else begin : g_on
      assign usable[k] = evt_i[k];
    end
  end

  assign hit_o = usable[sel_i];
endmodule

// File: rtl/cec_sat_counter.sv
module cec_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         hit_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         irq_en_i,
  input  logic         clr_i,
  output logic [W-1:0] count_o,
  output logic         flag_o
);
  localparam logic [W-1:0] TOP = '1;

  logic advance, reach;

  // A write owns the cycle; a pulse in the same cycle is lost.
  assign advance = en_i && hit_i && !wr_i && (count_o != TOP);
  assign reach   = advance && (count_o == TOP - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)       count_o <= '0;
    else if (wr_i)    count_o <= wdata_i;
    else if (advance) count_o <= count_o + 1'b1;
  end

  // Setting beats a clear in the same cycle so no saturation is missed.
  always_ff @(posedge clk) begin
    if (!rst_n)                  flag_o <= 1'b0;
    else if (reach && irq_en_i)  flag_o <= 1'b1;
    else if (clr_i)              flag_o <= 1'b0;
  end
endmodule

// File: rtl/cache_evt_counters.sv
module cache_evt_counters
  import cec_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:1]  evt_i,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CNT_W-1:0]    bus_wdata,
  output logic [CNT_W-1:0]    bus_rdata,
  output logic                irq_o
);
  logic                            ctrl_en_q;
  logic [NUM_CNT-1:0][CFG_W-1:0]   cfg_q;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_val;
  logic [NUM_CNT-1:0]              cnt_wr;
  logic [NUM_CNT-1:0]              sat_flag;
  logic [NUM_CNT-1:0]              irq_en;
  logic [NUM_CNT-1:0]              hit;
  logic                            wr_req;
  logic [CNT_W-1:0]                rd_next;

  assign wr_req = bus_valid && bus_write;

  always_ff @(posedge clk) begin
    if (!rst_n)                                  ctrl_en_q <= 1'b0;
    else if (wr_req && bus_addr == CTRL_ADDR)    ctrl_en_q <= bus_wdata[0];
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)                                cfg_q[i] <= '0;
      else if (wr_req && bus_addr == cfg_addr(i)) cfg_q[i] <= bus_wdata[CFG_W-1:0];
    end

    assign cnt_wr[i] = wr_req && (bus_addr == val_addr(i));
    assign irq_en[i] = |cfg_q[i][IRQ_W-1:0];

    cec_evt_select #(.HAS_EXT(HAS_EXT)) u_sel (
      .evt_i (evt_i),
      .sel_i (cfg_q[i][CFG_W-1:IRQ_W]),
      .hit_o (hit[i])
    );

    cec_sat_counter #(.W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (ctrl_en_q),
      .hit_i    (hit[i]),
      .wr_i     (cnt_wr[i]),
      .wdata_i  (bus_wdata),
      .irq_en_i (irq_en[i]),
      .clr_i    (wr_req && bus_addr == STAT_ADDR && bus_wdata[i]),
      .count_o  (cnt_val[i]),
      .flag_o   (sat_flag[i])
    );
  end

  assign irq_o = |(sat_flag & irq_en);

  always_comb begin
    rd_next = '0;
    if (bus_addr == CTRL_ADDR) rd_next[0] = ctrl_en_q;
    if (bus_addr == STAT_ADDR) rd_next[NUM_CNT-1:0] = sat_flag;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (bus_addr == cfg_addr(i)) rd_next[CFG_W-1:0] = cfg_q[i];
      if (bus_addr == val_addr(i)) rd_next = cnt_val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       bus_rdata <= '0;
    else if (bus_valid && !bus_write) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/cec_checker.sv
module cec_checker
  import cec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          enable,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CNT-1:0]            cnt_wr,
  input logic [NUM_CNT-1:0]            flags,
  input logic [CNT_W-1:0]              wdata
);
  localparam logic [CNT_W-1:0] TOP = '1;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[i] == TOP && !cnt_wr[i]) |=> cnt[i] == TOP);

    assert_gate_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !cnt_wr[i]) |=> $stable(cnt[i]));

    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr[i] |=> (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + 1'b1));

    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr[i] |=> cnt[i] == $past(wdata));

    assert_flag_at_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[i]) |-> cnt[i] == TOP);
  end
endmodule

bind cache_evt_counters cec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .enable (ctrl_en_q),
  .cnt    (cnt_val),
  .cnt_wr (cnt_wr),
  .flags  (sat_flag),
  .wdata  (bus_wdata)
);

// File: tb/cache_evt_counters_test.sv
`timescale 1ns/1ps
module cache_evt_counters_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] evt_i = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  cache_evt_counters uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [15:0] mask, input int times);
    for (int k = 0; k < times; k++) begin
      evt_i = mask[15:1];
      @(negedge clk);
      evt_i = '0;
    end
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    rd_check("R1 ctrl", 8'h00, 0);
    rd_check("R1 status", 8'h04, 0);
    rd_check("R1 cfg0", 8'h0C, 0);
    rd_check("R1 cfg1", 8'h08, 0);
    rd_check("R1 val0", 8'h14, 0);
    rd_check("R1 val1", 8'h10, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_enable();
    wr(8'h0C, 32'h4);             // counter 0 source 1
    pulse(16'h0002, 3);
    rd_check("R2 gated count", 8'h14, 0);
    wr(8'h00, 32'hFF);
    rd_check("R2 ctrl readback", 8'h00, 1);
    pulse(16'h0002, 2);
    rd_check("R2 enabled count", 8'h14, 2);
  endtask

  task automatic t_select();
    wr(8'h14, 0); wr(8'h10, 0);
    wr(8'h0C, 32'h2 << 2);        // counter 0: data read hit
    wr(8'h08, 32'h5 << 2);        // counter 1: data write request
    pulse(16'h0004, 3);
    pulse(16'h0020, 2);
    pulse(16'h0008, 1);
    pulse(16'h0024, 1);
    rd_check("R4 src2 count", 8'h14, 4);
    rd_check("R4 src5 count", 8'h10, 3);
    wr(8'h14, 7);
    wr(8'h0C, 0);                 // code 0: disabled
    pulse(16'hFFFE, 2);
    rd_check("R4 disabled code", 8'h14, 7);
  endtask

  task automatic t_ext();
    wr(8'h14, 0); wr(8'h10, 0);
    wr(8'h0C, 32'hC << 2);
    wr(8'h08, 32'hF << 2);
    pulse(16'h1000, 2);
    pulse(16'h8000, 1);
    pulse(16'h0200, 1);           // base event 9 must not count here
    rd_check("R5 ext 0xC", 8'h14, 2);
    rd_check("R5 ext 0xF", 8'h10, 1);
  endtask

  task automatic t_order();
    wr(8'h14, 32'h55);
    wr(8'h10, 32'hAA);
    rd_check("R6 val0 at 0x14", 8'h14, 32'h55);
    rd_check("R6 val1 at 0x10", 8'h10, 32'hAA);
    wr(8'h0C, 32'h2D);
    rd_check("R6 cfg0 at 0x0C", 8'h0C, 32'h2D);
    rd_check("R6 cfg1 at 0x08", 8'h08, 32'hF << 2);
    rd_check("R10 unmapped", 8'h20, 0);
  endtask

  task automatic t_priority();
    wr(8'h0C, 32'h1 << 2);
    evt_i = 15'h0001;             // event 1 in the write cycle
    wr(8'h14, 100);
    evt_i = '0;
    rd_check("R7 write wins", 8'h14, 100);
    pulse(16'h0002, 1);
    rd_check("R7 count after write", 8'h14, 101);
  endtask

  task automatic t_sat();
    wr(8'h0C, (32'h1 << 2) | 32'h1);
    wr(8'h14, 32'hFFFF_FFFD);
    pulse(16'h0002, 1);
    check("R8 no flag below top", {31'b0, irq_o}, 0);
    rd_check("R8 status clear", 8'h04, 0);
    pulse(16'h0002, 1);
    check("R9 irq on saturation", {31'b0, irq_o}, 1);
    rd_check("R8 status set", 8'h04, 1);
    pulse(16'h0002, 3);
    rd_check("R3 held at top", 8'h14, 32'hFFFF_FFFF);
    rd_check("R8 sticky", 8'h04, 1);
    wr(8'h04, 32'h1);
    check("R9 irq cleared", {31'b0, irq_o}, 0);
    rd_check("R8 w1c", 8'h04, 0);
    pulse(16'h0002, 2);
    rd_check("R3 still top", 8'h14, 32'hFFFF_FFFF);
    rd_check("R8 no reflag at top", 8'h04, 0);
    wr(8'h08, 32'h2 << 2);        // counter 1, interrupt field 0
    wr(8'h10, 32'hFFFF_FFFE);
    pulse(16'h0004, 1);
    rd_check("R3 cnt1 top", 8'h10, 32'hFFFF_FFFF);
    rd_check("R8 masked no flag", 8'h04, 0);
    check("R9 masked irq", {31'b0, irq_o}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_select();
    t_ext();
    t_order();
    t_priority();
    t_sat();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule